// File: doc/BRIEF.md
# Transport Packet Sync Lock Detector

This block recovers packet boundaries from a byte-wide transport stream. While out of lock it searches every valid byte for a programmable sync token. It then checks that the token appears again exactly one packet length later, and again after that. When a run of correctly spaced tokens reaches the lock threshold, the block declares lock and starts forwarding whole packets. It marks the sync byte of each packet as start of packet. If too many consecutive expected sync positions carry the wrong value, lock is dropped and the search starts over.

All four settings come in on input ports: the token value, the packet length, the acquisition threshold and the loss threshold. They are expected to stay constant while the block is out of reset. Typical settings are token 0x47, length 188, and nine hits to lock and nine misses to drop. Input bytes arrive with a valid strobe, and idle cycles may appear anywhere in the stream. Each output byte is registered and comes with its own valid strobe.

Top module: `ts_sync_lock`

## Requirements
- R1: While rst_ni is low, lock_o, pkt_vld_o and sop_o are all 0.
- R2: Bytes that arrive while the block is not locked are never presented: pkt_vld_o stays 0 for them.
- R3: Lock is declared when the sync token has been seen lock_thr_i times in a row, each exactly pkt_len_i valid bytes after the previous one. The sync byte that completes the run is the first byte forwarded. It appears with sop_o=1, and lock_o rises at the same edge.
- R4: While lock is being acquired, a byte at the expected sync position that is not the token discards the run. The search resumes with the following byte, and a full new run of lock_thr_i hits is then needed.
- R5: While locked, every valid input byte is presented on data_o with pkt_vld_o=1 one clock edge after it is accepted. sop_o is 1 exactly on the bytes at packet boundaries, every pkt_len_i valid bytes.
- R6: While locked, when drop_thr_i consecutive boundary bytes are not the token, lock_o falls. The boundary byte that reaches the limit is not forwarded, and neither is any byte after it until lock is regained.
- R7: While locked, a single boundary byte equal to the token clears the run of misses. Further misses then count from zero again.
- R8: A cycle with byte_vld_i=0 produces no output strobe and does not advance the position within a packet.
- R9: The token value and packet length are taken from the ports. A threshold of 0 behaves as 1, so lock_thr_i of 0 or 1 locks on the first token seen. drop_thr_i of 0 or 1 drops lock on the first miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_token_i | input | DATA_W | Sync token value |
| pkt_len_i | input | LEN_W | Packet length in bytes, including the sync byte (at least 2) |
| lock_thr_i | input | THR_W | Consecutive hits needed to lock |
| drop_thr_i | input | THR_W | Consecutive misses needed to drop lock |
| byte_i | input | DATA_W | Input stream byte |
| byte_vld_i | input | 1 | Input byte valid |
| data_o | output | DATA_W | Forwarded byte |
| sop_o | output | 1 | Forwarded byte is the sync byte of a packet |
| pkt_vld_o | output | 1 | data_o carries a forwarded byte |
| lock_o | output | 1 | Block is locked to the stream |

## Verification
Every forwarded byte leaves through a single output register, so it is due at the first rising edge after the edge that accepts it. lock_o changes at that same edge, together with the first forwarded byte or the first byte withheld. The bench drives inputs just after a rising edge. A monitor samples the outputs on every falling edge and pops one expected byte per pkt_vld_o. Lock status is read right after the edge that took the last byte of a packet. Idle cycles are inserted between bytes in one scenario, so the one-edge latency is checked both with idle cycles and without them.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CAND = 2'd1,
    ST_LOCK = 2'd2
  } sync_state_e;
endpackage

// File: rtl/ts_sync_pos_ctr.sv
module ts_sync_pos_ctr #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             inc_i,
  output logic             at_bnd_o
);
  logic [LEN_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (load_i) pos_q <= LEN_W'(1);
    else if (inc_i)  pos_q <= pos_q + LEN_W'(1);
  end

  // next valid byte sits on the expected sync position
  assign at_bnd_o = (pos_q == len_i);

  p_pos_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= len_i);
endmodule

// File: rtl/ts_sync_run_ctr.sv
module ts_sync_run_ctr #(
  parameter int unsigned THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [THR_W-1:0] cnt_o
);
  logic [THR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= inc_i ? THR_W'(1) : '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + THR_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock
  import ts_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned THR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sync_token_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [THR_W-1:0]  lock_thr_i,
  input  logic [THR_W-1:0]  drop_thr_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sop_o,
  output logic              pkt_vld_o,
  output logic              lock_o
);
  localparam int unsigned CW = THR_W + 1;

  sync_state_e state_q, state_d;
  logic [THR_W-1:0] hit_cnt, miss_cnt, lthr, dthr;
  logic tok, at_bnd, hit_reach, miss_reach;
  logic pos_clr, pos_load, pos_inc;
  logic hit_clr, hit_inc, miss_clr, miss_inc;
  logic fwd, sop;

  assign tok        = (byte_i == sync_token_i);
  assign lthr       = (lock_thr_i == '0) ? THR_W'(1) : lock_thr_i;
  assign dthr       = (drop_thr_i == '0) ? THR_W'(1) : drop_thr_i;
  assign hit_reach  = ({1'b0, hit_cnt}  + CW'(1)) >= {1'b0, lthr};
  assign miss_reach = ({1'b0, miss_cnt} + CW'(1)) >= {1'b0, dthr};

  ts_sync_pos_ctr #(.LEN_W(LEN_W)) u_pos (
    .clk_i, .rst_ni, .len_i(pkt_len_i),
    .clr_i(pos_clr), .load_i(pos_load), .inc_i(pos_inc), .at_bnd_o(at_bnd)
  );

  ts_sync_run_ctr #(.THR_W(THR_W)) u_hit (
    .clk_i, .rst_ni, .clr_i(hit_clr), .inc_i(hit_inc), .cnt_o(hit_cnt)
  );

  ts_sync_run_ctr #(.THR_W(THR_W)) u_miss (
    .clk_i, .rst_ni, .clr_i(miss_clr), .inc_i(miss_inc), .cnt_o(miss_cnt)
  );

  always_comb begin
    state_d  = state_q;
    fwd      = 1'b0;
    sop      = 1'b0;
    pos_clr  = 1'b0;
    pos_load = 1'b0;
    pos_inc  = 1'b0;
    hit_clr  = 1'b0;
    hit_inc  = 1'b0;
    miss_clr = 1'b0;
    miss_inc = 1'b0;
    if (byte_vld_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (tok) begin
            pos_load = 1'b1;
            hit_clr  = 1'b1;
            hit_inc  = 1'b1;
            miss_clr = 1'b1;
            if (lthr == THR_W'(1)) begin
              state_d = ST_LOCK;
              fwd     = 1'b1;
              sop     = 1'b1;
            end else begin
              state_d = ST_CAND;
            end
          end else begin
            pos_clr = 1'b1;
          end
        end
        ST_CAND: begin
          if (!at_bnd) begin
            pos_inc = 1'b1;
          end else if (tok) begin
            pos_load = 1'b1;
            hit_inc  = 1'b1;
            if (hit_reach) begin
              state_d  = ST_LOCK;
              fwd      = 1'b1;
              sop      = 1'b1;
              miss_clr = 1'b1;
            end
          end else begin
            // wrong byte at expected spacing: restart search
            state_d = ST_HUNT;
            pos_clr = 1'b1;
            hit_clr = 1'b1;
          end
        end
        ST_LOCK: begin
          if (!at_bnd) begin
            fwd     = 1'b1;
            pos_inc = 1'b1;
          end else if (tok) begin
            fwd      = 1'b1;
            sop      = 1'b1;
            pos_load = 1'b1;
            miss_clr = 1'b1;
          end else if (miss_reach) begin
            state_d  = ST_HUNT;
            pos_clr  = 1'b1;
            hit_clr  = 1'b1;
            miss_clr = 1'b1;
          end else begin
            // tolerated miss: keep flywheel alignment
            fwd      = 1'b1;
            sop      = 1'b1;
            pos_load = 1'b1;
            miss_inc = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      data_o    <= '0;
      sop_o     <= 1'b0;
      pkt_vld_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sop_o     <= sop;
      pkt_vld_o <= fwd;
      if (fwd) data_o <= byte_i;
    end
  end

  assign lock_o = (state_q == ST_LOCK);

  p_sop_has_vld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> pkt_vld_o);
  p_fwd_only_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> lock_o);
  p_lock_starts_sop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (sop_o && pkt_vld_o));
  p_drop_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> !pkt_vld_o);
  p_idle_no_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !pkt_vld_o);
  p_miss_below_thr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (miss_cnt < dthr));
  p_cand_hits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAND) |-> (hit_cnt != '0 && hit_cnt < lthr));
endmodule

// File: tb/tb_ts_sync_lock.sv
module tb_ts_sync_lock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sync_token_i = 8'h47;
  logic [7:0] pkt_len_i = 8'd188;
  logic [3:0] lock_thr_i = 4'd9;
  logic [3:0] drop_thr_i = 4'd9;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic [7:0] data_o;
  logic       sop_o, pkt_vld_o, lock_o;

  int checks = 0;
  int fails = 0;
  int seed = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  ts_sync_lock dut (
    .clk_i, .rst_ni, .sync_token_i, .pkt_len_i, .lock_thr_i, .drop_thr_i,
    .byte_i, .byte_vld_i, .data_o, .sop_o, .pkt_vld_o, .lock_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && pkt_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected output byte", {sop_o, data_o}, 0);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({sop_o, data_o} == e, t, "sop/data", {sop_o, data_o}, e);
      end
    end
  end

  task automatic drive(input logic [7:0] b, input int gap);
    for (int g = 0; g < gap; g++) begin
      byte_vld_i = 1'b0;
      @(posedge clk_i); #1;
    end
    byte_vld_i = 1'b1;
    byte_i = b;
    @(posedge clk_i); #1;
    byte_vld_i = 1'b0;
  endtask

  task automatic send_pkt(input bit good, input bit fwd, input int gap,
                          input string tag);
    for (int i = 0; i < int'(pkt_len_i); i++) begin
      logic [7:0] b;
      if (i == 0) b = good ? sync_token_i : ~sync_token_i;
      else begin
        b = 8'(seed * 7 + 3);
        seed++;
        if (b == sync_token_i) b = b ^ 8'h01;
      end
      if (fwd) begin
        exp_q.push_back({(i == 0), b});
        tag_q.push_back(tag);
      end
      drive(b, gap);
    end
  endtask

  task automatic do_reset(input logic [7:0] tok, input logic [7:0] len,
                          input logic [3:0] lt, input logic [3:0] dt);
    rst_ni = 1'b0;
    sync_token_i = tok;
    pkt_len_i = len;
    lock_thr_i = lt;
    drop_thr_i = dt;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!lock_o && !pkt_vld_o && !sop_o, "R1", "reset outputs",
        {lock_o, pkt_vld_o, sop_o}, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic chk_lock(input logic exp, input string tag);
    chk(lock_o == exp, tag, "lock_o", lock_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // typical settings
    do_reset(8'h47, 8'd188, 4'd9, 4'd9);
    for (int i = 0; i < 20; i++) drive(8'(i + 8'h60), 0);   // R2 junk, no token
    for (int i = 0; i < 8; i++) send_pkt(1, 0, 0, "R2");
    chk_lock(1'b0, "R3");
    send_pkt(1, 1, 0, "R3");
    chk_lock(1'b1, "R3");
    for (int i = 0; i < 3; i++) send_pkt(1, 1, 0, "R5");
    for (int i = 0; i < 8; i++) send_pkt(0, 1, 0, "R7");
    send_pkt(1, 1, 0, "R7");
    for (int i = 0; i < 8; i++) send_pkt(0, 1, 0, "R7");
    chk_lock(1'b1, "R7");
    send_pkt(0, 0, 0, "R6");
    chk_lock(1'b0, "R6");
    send_pkt(1, 0, 0, "R2");
    chk(exp_q.size() == 0, "R5", "pending bytes", exp_q.size(), 0);

    // other token/length, idle gaps, broken run
    do_reset(8'hB8, 8'd12, 4'd3, 4'd2);
    send_pkt(1, 0, 1, "R4");
    send_pkt(1, 0, 2, "R4");
    send_pkt(0, 0, 1, "R4");
    send_pkt(1, 0, 1, "R4");
    send_pkt(1, 0, 3, "R4");
    chk_lock(1'b0, "R4");
    send_pkt(1, 1, 2, "R8");
    chk_lock(1'b1, "R3");
    send_pkt(0, 1, 1, "R8");
    send_pkt(1, 1, 0, "R7");
    send_pkt(0, 1, 2, "R7");
    chk_lock(1'b1, "R7");
    send_pkt(0, 0, 1, "R6");
    chk_lock(1'b0, "R6");
    chk(exp_q.size() == 0, "R8", "pending bytes", exp_q.size(), 0);

    // zero thresholds act as one
    do_reset(8'h5A, 8'd8, 4'd0, 4'd0);
    send_pkt(1, 1, 0, "R9");
    chk_lock(1'b1, "R9");
    send_pkt(0, 0, 0, "R9");
    chk_lock(1'b0, "R9");
    repeat (4) @(posedge clk_i);
    #1;
    chk(exp_q.size() == 0, "R9", "pending bytes", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule